// File: doc/BRIEF.md
# Bit-Slice Four-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. Each result bit comes from a one-bit slice, and the slices are chained through a ripple carry. The low slices all share one design. The most-significant slice is a separate design, because it also produces the signed less-than decision and the raw two's-complement overflow. A small decoder turns the 4-bit operation code into a few controls: an operand-A invert, an operand-B invert that also serves as the carry into bit 0, a result-path pick and an arithmetic flag.

Operands are two's-complement values. Subtraction adds the inverted B with a carry-in of one. NOR and NAND reuse the AND and OR paths with both operands inverted. Two extra operations act on operand A alone: an arithmetic shift right by one and a rotate left by one. The data width is a parameter (default 4). The operation code is always 4 bits wide.

Top module: `bitslice_alu`

## Requirements
- R1: Code 0000 gives the bitwise AND of A and B. Code 0001 gives the bitwise OR of A and B.
- R2: Code 0010 gives A plus B modulo 2^WIDTH.
- R3: Code 0110 gives A minus B modulo 2^WIDTH.
- R4: Code 0111 gives result 1 when signed A is less than signed B, and 0 otherwise. The decision is correct even when A minus B overflows. Result bits above bit 0 are always 0.
- R5: Code 1100 gives the bitwise NOR of A and B. Code 1101 gives the bitwise NAND of A and B.
- R6: `zero` is 1 exactly when every result bit is 0.
- R7: For code 0010, `overflow` is 1 exactly when the signed sum overflows. For codes 0110 and 0111, `overflow` is 1 exactly when the signed difference A minus B overflows.
- R8: `overflow` is 0 for every code other than 0010, 0110 and 0111.
- R9: Code 1000 gives A shifted right by one bit, with the sign bit A[WIDTH-1] copied into the top bit.
- R10: Code 1001 gives A rotated left by one bit, so that A[WIDTH-1] moves into bit 0.
- R11: Every code not listed above gives a result of 0, `zero` 1 and `overflow` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a | input | WIDTH | Operand A, two's complement |
| b | input | WIDTH | Operand B, two's complement |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the arithmetic operations |

## Verification
The embedded assertions watch several properties whenever the inputs settle:
- overflow stays low outside the arithmetic codes;
- set-on-less-than never drives bits above bit 0;
- unlisted codes give a zero result;
- an addition overflow only occurs with equal operand signs and a flipped result sign;
- the shift keeps the sign bit;
- the rotate keeps the number of ones;
- `zero` agrees with the result.

Only the bench's scenarios can show the exact arithmetic values. This includes the wrapped sums and differences, the less-than decision across the overflow boundary, and the exact bit placement of the shift and rotate. The bench covers these with a table of corner cases and then an exhaustive sweep of every code and operand pair.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

   localparam int OP_W = 4;

   localparam logic [OP_W-1:0] OP_AND  = 4'b0000;
   localparam logic [OP_W-1:0] OP_OR   = 4'b0001;
   localparam logic [OP_W-1:0] OP_ADD  = 4'b0010;
   localparam logic [OP_W-1:0] OP_SUB  = 4'b0110;
   localparam logic [OP_W-1:0] OP_SLT  = 4'b0111;
   localparam logic [OP_W-1:0] OP_SHR  = 4'b1000;
   localparam logic [OP_W-1:0] OP_ROL  = 4'b1001;
   localparam logic [OP_W-1:0] OP_NOR  = 4'b1100;
   localparam logic [OP_W-1:0] OP_NAND = 4'b1101;

   typedef enum logic [2:0] {
      PICK_AND  = 3'd0,
      PICK_OR   = 3'd1,
      PICK_SUM  = 3'd2,
      PICK_LESS = 3'd3,
      PICK_SHR  = 3'd4,
      PICK_ROL  = 3'd5,
      PICK_NONE = 3'd6
   } pick_t;

endpackage

// File: rtl/bsalu_decode.sv
module bsalu_decode
   import bsalu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output logic            a_inv,
   output logic            b_inv,
   output pick_t           pick,
   output logic            arith
);

   always_comb begin
      a_inv = 1'b0;
      b_inv = 1'b0;
      arith = 1'b0;
      pick  = PICK_NONE;
      case (op)
         OP_AND:  pick = PICK_AND;
         OP_OR:   pick = PICK_OR;
         OP_ADD:  begin pick = PICK_SUM; arith = 1'b1; end
         OP_SUB:  begin pick = PICK_SUM; arith = 1'b1; b_inv = 1'b1; end
         OP_SLT:  begin pick = PICK_LESS; arith = 1'b1; b_inv = 1'b1; end
         OP_NOR:  begin pick = PICK_AND; a_inv = 1'b1; b_inv = 1'b1; end
         OP_NAND: begin pick = PICK_OR;  a_inv = 1'b1; b_inv = 1'b1; end
         OP_SHR:  pick = PICK_SHR;
         OP_ROL:  pick = PICK_ROL;
         default: pick = PICK_NONE;
      endcase
   end

   // R8: only arithmetic codes may raise the arithmetic flag
   always_comb begin
      if (!$isunknown(op)) begin
         p_arith_codes_r8: assert (!arith || op == OP_ADD || op == OP_SUB || op == OP_SLT)
            else $error("arith flag raised for non-arithmetic code");
      end
   end

endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
   import bsalu_pkg::*;
(
   input  logic  a,
   input  logic  b,
   input  logic  a_inv,
   input  logic  b_inv,
   input  logic  cin,
   input  logic  less,
   input  logic  shr_src,
   input  logic  rol_src,
   input  pick_t pick,
   output logic  res,
   output logic  cout
);

   logic a_eff;
   logic b_eff;
   logic sum;

   assign a_eff = a ^ a_inv;
   assign b_eff = b ^ b_inv;
   assign sum   = a_eff ^ b_eff ^ cin;
   assign cout  = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);

   always_comb begin
      case (pick)
         PICK_AND:  res = a_eff & b_eff;
         PICK_OR:   res = a_eff | b_eff;
         PICK_SUM:  res = sum;
         PICK_LESS: res = less;
         PICK_SHR:  res = shr_src;
         PICK_ROL:  res = rol_src;
         default:   res = 1'b0;
      endcase
   end

endmodule

// File: rtl/bsalu_slice_msb.sv
module bsalu_slice_msb
   import bsalu_pkg::*;
(
   input  logic  a,
   input  logic  b,
   input  logic  a_inv,
   input  logic  b_inv,
   input  logic  cin,
   input  logic  shr_src,
   input  logic  rol_src,
   input  pick_t pick,
   output logic  res,
   output logic  set,
   output logic  ovf_raw
);

   logic a_eff;
   logic b_eff;
   logic sum;
   logic cout;

   assign a_eff   = a ^ a_inv;
   assign b_eff   = b ^ b_inv;
   assign sum     = a_eff ^ b_eff ^ cin;
   assign cout    = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);
   assign ovf_raw = cin ^ cout;
   // sign of the difference corrected by overflow
   assign set     = sum ^ ovf_raw;

   always_comb begin
      case (pick)
         PICK_AND:  res = a_eff & b_eff;
         PICK_OR:   res = a_eff | b_eff;
         PICK_SUM:  res = sum;
         PICK_SHR:  res = shr_src;
         PICK_ROL:  res = rol_src;
         default:   res = 1'b0;
      endcase
   end

   // R7: overflow means equal effective signs and a flipped sum sign
   always_comb begin
      if (!$isunknown({a_eff, b_eff, cin})) begin
         p_ovf_form_r7: assert (ovf_raw == ((a_eff == b_eff) && (sum != a_eff)))
            else $error("overflow disagrees with sign rule");
      end
   end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import bsalu_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [OP_W-1:0]  op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             overflow
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("bitslice_alu needs WIDTH of at least 2");
   end

   logic       a_inv;
   logic       b_inv;
   logic       arith;
   pick_t      pick;
   logic [MSB:0] carry;
   logic       set_w;
   logic       ovf_raw;

   bsalu_decode u_decode (
      .op    (op),
      .a_inv (a_inv),
      .b_inv (b_inv),
      .pick  (pick),
      .arith (arith)
   );

   assign carry[0] = b_inv;

   for (genvar i = 0; i < MSB; i++) begin : g_low
      logic rol_in;
      logic less_in;
      if (i == 0) begin : g_first
         assign rol_in  = a[MSB];
         assign less_in = set_w;
      end else begin : g_mid
         assign rol_in  = a[i-1];
         assign less_in = 1'b0;
      end
      bsalu_slice u_slice (
         .a       (a[i]),
         .b       (b[i]),
         .a_inv   (a_inv),
         .b_inv   (b_inv),
         .cin     (carry[i]),
         .less    (less_in),
         .shr_src (a[i+1]),
         .rol_src (rol_in),
         .pick    (pick),
         .res     (result[i]),
         .cout    (carry[i+1])
      );
   end

   bsalu_slice_msb u_msb (
      .a       (a[MSB]),
      .b       (b[MSB]),
      .a_inv   (a_inv),
      .b_inv   (b_inv),
      .cin     (carry[MSB]),
      .shr_src (a[MSB]),
      .rol_src (a[MSB-1]),
      .pick    (pick),
      .res     (result[MSB]),
      .set     (set_w),
      .ovf_raw (ovf_raw)
   );

   assign zero     = ~|result;
   assign overflow = arith & ovf_raw;

   always_comb begin
      if (!$isunknown({op, a, b})) begin
         p_no_overflow_r8: assert (overflow == 1'b0 || op == OP_ADD || op == OP_SUB || op == OP_SLT)
            else $error("overflow on non-arithmetic code");
         p_slt_high_clear_r4: assert (op != OP_SLT || result[MSB:1] == '0)
            else $error("set-on-less-than drove upper bits");
         p_add_ovf_signs_r7: assert (op != OP_ADD || !overflow || (a[MSB] == b[MSB] && result[MSB] != a[MSB]))
            else $error("add overflow without sign condition");
         p_shr_sign_r9: assert (op != OP_SHR || result[MSB] == a[MSB])
            else $error("shift lost sign bit");
         p_rol_ones_r10: assert (op != OP_ROL || $countones(result) == $countones(a))
            else $error("rotate changed ones count");
         p_zero_flag_r6: assert (!zero || result == '0)
            else $error("zero flag with nonzero result");
         p_unlisted_r11: assert (op == OP_AND || op == OP_OR || op == OP_ADD || op == OP_SUB ||
                                 op == OP_SLT || op == OP_NOR || op == OP_NAND || op == OP_SHR ||
                                 op == OP_ROL || (result == '0 && !overflow))
            else $error("unlisted code produced output");
      end
   end

endmodule

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;

   localparam int W = 4;
   localparam int NVEC = 19;

   // {op, a, b, result, zero, overflow}
   localparam logic [17:0] VECS [NVEC] = '{
      {4'b0000, 4'b1100, 4'b1010, 4'b1000, 1'b0, 1'b0},
      {4'b0001, 4'b1100, 4'b1010, 4'b1110, 1'b0, 1'b0},
      {4'b0010, 4'b0011, 4'b0100, 4'b0111, 1'b0, 1'b0},
      {4'b0010, 4'b0111, 4'b0001, 4'b1000, 1'b0, 1'b1},
      {4'b0010, 4'b1000, 4'b1000, 4'b0000, 1'b1, 1'b1},
      {4'b0110, 4'b0101, 4'b0011, 4'b0010, 1'b0, 1'b0},
      {4'b0110, 4'b0011, 4'b0011, 4'b0000, 1'b1, 1'b0},
      {4'b0110, 4'b1000, 4'b0001, 4'b0111, 1'b0, 1'b1},
      {4'b0111, 4'b1110, 4'b0001, 4'b0001, 1'b0, 1'b0},
      {4'b0111, 4'b1000, 4'b0001, 4'b0001, 1'b0, 1'b1},
      {4'b0111, 4'b0011, 4'b1111, 4'b0000, 1'b1, 1'b0},
      {4'b0111, 4'b0111, 4'b1000, 4'b0000, 1'b1, 1'b1},
      {4'b1100, 4'b1100, 4'b1010, 4'b0001, 1'b0, 1'b0},
      {4'b1101, 4'b1100, 4'b1010, 4'b0111, 1'b0, 1'b0},
      {4'b1000, 4'b1010, 4'b0000, 4'b1101, 1'b0, 1'b0},
      {4'b1000, 4'b0110, 4'b0000, 4'b0011, 1'b0, 1'b0},
      {4'b1001, 4'b1010, 4'b0000, 4'b0101, 1'b0, 1'b0},
      {4'b1001, 4'b1000, 4'b0000, 4'b0001, 1'b0, 1'b0},
      {4'b0011, 4'b1111, 4'b1111, 4'b0000, 1'b1, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [3:0]   op;
   logic [W-1:0] a;
   logic [W-1:0] b;
   logic [W-1:0] result;
   logic         zero;
   logic         overflow;

   int n_checks = 0;
   int n_fail   = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   bitslice_alu #(.WIDTH(W)) u_bitslice_alu (
      .op       (op),
      .a        (a),
      .b        (b),
      .result   (result),
      .zero     (zero),
      .overflow (overflow)
   );

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'b0000, 4'b0001: return "R1";
         4'b0010:          return "R2";
         4'b0110:          return "R3";
         4'b0111:          return "R4";
         4'b1100, 4'b1101: return "R5";
         4'b1000:          return "R9";
         4'b1001:          return "R10";
         default:          return "R11";
      endcase
   endfunction

   // reference model written from the requirements
   task automatic model(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y,
                        output logic [W-1:0] r, output logic v);
      logic [W-1:0] d;
      v = 1'b0;
      case (c)
         4'b0000: r = x & y;
         4'b0001: r = x | y;
         4'b0010: begin r = x + y; v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]); end
         4'b0110: begin r = x - y; v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]); end
         4'b0111: begin
            d = x - y;
            v = (x[W-1] != y[W-1]) && (d[W-1] != x[W-1]);
            r = ($signed(x) < $signed(y)) ? W'(1) : W'(0);
         end
         4'b1100: r = ~(x | y);
         4'b1101: r = ~(x & y);
         4'b1000: r = {x[W-1], x[W-1:1]};
         4'b1001: r = {x[W-2:0], x[W-1]};
         default: r = '0;
      endcase
   endtask

   task automatic check(input string tag, input logic [W-1:0] er, input logic ez, input logic ev);
      n_checks++;
      if (result !== er || zero !== ez || overflow !== ev) begin
         n_fail++;
         $display("FAIL %s op=%b a=%b b=%b: actual r=%b z=%b v=%b expected r=%b z=%b v=%b",
                  tag, op, a, b, result, zero, overflow, er, ez, ev);
      end
   endtask

   task automatic apply(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
      @(negedge clk);
      op = c;
      a  = x;
      b  = y;
      @(posedge clk);
      #1;
   endtask

   initial begin
      op = 4'b0000;
      a  = '0;
      b  = '0;
      repeat (3) @(posedge clk);
      #1;
      // reset state: AND of zeros, R6 zero flag high, R8 no overflow
      check("R6_reset", 4'b0000, 1'b1, 1'b0);
      rst = 1'b0;

      for (int k = 0; k < NVEC; k++) begin
         apply(VECS[k][17:14], VECS[k][13:10], VECS[k][9:6]);
         check({req_of(VECS[k][17:14]), "_table"}, VECS[k][5:2], VECS[k][1], VECS[k][0]);
      end

      // exhaustive sweep, R6 zero and R7/R8 overflow for every code
      for (int c = 0; c < 16; c++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               logic [W-1:0] er;
               logic         ev;
               model(4'(c), 4'(x), 4'(y), er, ev);
               apply(4'(c), 4'(x), 4'(y));
               check({req_of(4'(c)), "_R6_R7_R8_sweep"}, er, (er == '0), ev);
            end
         end
      end

      // R4 corner: most negative versus most positive, both directions
      apply(4'b0111, 4'b1000, 4'b0111);
      check("R4_minmax", 4'b0001, 1'b0, 1'b1);
      apply(4'b0111, 4'b0111, 4'b1000);
      check("R4_maxmin", 4'b0000, 1'b1, 1'b1);
      // R11 unlisted code with all ones
      apply(4'b1111, 4'b1111, 4'b1111);
      check("R11_all_ones", 4'b0000, 1'b1, 1'b0);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule